// File: doc/BRIEF.md
# Display Mode Init Sequencer

This block brings a display controller's timing registers to a known state once after reset. On a start pulse it looks at an 8-bit status byte from the controller, and at a board strap, to decide which of three built-in timing tables applies. The three tables are 1152x900 at 66 Hz, 1152x900 at 76 Hz and 640x480. It then replays the chosen table as byte writes on a simple register-write bus, one write per clock.

Each table is a list of (register offset, value) pairs that ends at an offset of zero. The timing registers are written first and the control register last. A second built-in list then sets up the colour DAC. Each of its pairs becomes two bus writes: one to a DAC index port, then one to a DAC control port. When the walk ends the block raises `done`. If the monitor is not one it can drive, it raises `error` and writes nothing.

Top module: `dispInitSeq`

## Requirements
- R1: After reset, and until `start` is seen high, `wrStrobe`, `done` and `error` are all low.
- R2: With the strap low, a monitor ID of 0x1 in status bits [3:0] and a resolution code (bits [6:4]) of 4 or 6 select the 76 Hz table. Its values for offsets 0x14..0x1F are B7 27 03 0F AE 03 AE 2A 01 09 FF 01, and its control value is 0x24.
- R3: With the strap low, an ID of 0x1 and any other resolution code select the 66 Hz table. Its values for offsets 0x14..0x1F are BB 2B 04 14 AE 03 A8 24 01 05 FF 01, and its control value is 0x20. Status bit 7 has no effect on the choice.
- R4: With the strap high, the 640x480 table is used whatever the status byte holds. Its values for offsets 0x14..0x1F are 70 20 08 10 06 02 31 51 06 0C FF 01, and its control value is 0x22.
- R5: With the strap low and an ID other than 0x1, `error` rises and stays high, `done` stays low and no write is issued.
- R6: The timing pass writes offsets 0x14 through 0x1F in ascending order and then the control register at offset 0x10, for 13 writes. Each write is a single-cycle strobe. The control value written always has bit 6 clear.
- R7: After the timing pass, four DAC pairs are written. Each pair is a write to the DAC index port (offset 0x08) followed by a write to the DAC control port (offset 0x0A). The index/control pairs are (4,FF), (5,00), (6,70) and (7,00). A full run is therefore 21 writes.
- R8: `done` rises exactly once, after the last DAC write, and stays high. No write follows it.
- R9: The sequence runs once per reset. A `start` held high during a run does not change the write stream, and a later `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the init sequence (sampled in idle only) |
| statusByte | input | 8 | Controller status: [3:0] monitor ID, [6:4] resolution code, [7] interrupt pending |
| lowResStrap | input | 1 | Forces the 640x480 table |
| wrAddr | output | 8 | Register offset of the current write |
| wrData | output | 8 | Data of the current write |
| wrStrobe | output | 1 | Write qualifier, one cycle per write |
| done | output | 1 | Sequence finished |
| error | output | 1 | Unsupported monitor; nothing written |

## Verification
The assertions check the following on every cycle:
- timing-pass writes land only in the 0x10..0x1F window;
- a DAC control write is always preceded by a DAC index write;
- the bus stays silent once `done` or `error` is high;
- `done` and `error` never appear together and never drop;
- the sequencer never returns to idle.

Only the bench scenarios can show the rest. These cover which table a given status/strap pattern selects, the exact ordered values of each stream, that `done` rises a single time, and that a second `start` after completion produces no writes.

// File: rtl/initSeqPkg.sv
package initSeqPkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W = 4;
  localparam int TIMING_PAIRS = 13;
  localparam int DAC_PAIRS = 4;
  localparam logic [3:0] ID_COLOUR = 4'h1;
  localparam logic [2:0] RES_FAST_A = 3'd4;
  localparam logic [2:0] RES_FAST_B = 3'd6;

  typedef enum logic [1:0] {MODE_66 = 2'd0, MODE_76 = 2'd1, MODE_LOW = 2'd2} modeT;
  typedef enum logic [1:0] {BUS_TIMING = 2'd0, BUS_DAC_IDX = 2'd1, BUS_DAC_CTRL = 2'd2} busSelT;

  typedef struct packed {
    logic   loadMode;
    logic   clrIdx;
    logic   stepIdx;
    logic   selDac;
    busSelT busSel;
    logic   strobe;
  } seqCmdT;
endpackage

// File: rtl/seqRom.sv
module seqRom
  import initSeqPkg::*;
(
  input  modeT              mode,
  input  logic              selDac,
  input  logic [IDX_W-1:0]  pairIdx,
  output logic [BYTE_W-1:0] keyByte,
  output logic [BYTE_W-1:0] valByte
);
  localparam logic [BYTE_W-1:0] FIRST_TIMING = 8'h14;
  localparam logic [BYTE_W-1:0] CTRL_OFFSET  = 8'h10;
  localparam logic [BYTE_W-1:0] FIRST_DAC    = 8'h04;

  logic [3*BYTE_W-1:0] rowVals;
  logic [BYTE_W-1:0] idxByte;

  assign idxByte = BYTE_W'(pairIdx);

  // one row per pair: {66 Hz, 76 Hz, 640x480}
  always_comb begin
    case (pairIdx)
      4'd0:    rowVals = {8'hBB, 8'hB7, 8'h70};
      4'd1:    rowVals = {8'h2B, 8'h27, 8'h20};
      4'd2:    rowVals = {8'h04, 8'h03, 8'h08};
      4'd3:    rowVals = {8'h14, 8'h0F, 8'h10};
      4'd4:    rowVals = {8'hAE, 8'hAE, 8'h06};
      4'd5:    rowVals = {8'h03, 8'h03, 8'h02};
      4'd6:    rowVals = {8'hA8, 8'hAE, 8'h31};
      4'd7:    rowVals = {8'h24, 8'h2A, 8'h51};
      4'd8:    rowVals = {8'h01, 8'h01, 8'h06};
      4'd9:    rowVals = {8'h05, 8'h09, 8'h0C};
      4'd10:   rowVals = {8'hFF, 8'hFF, 8'hFF};
      4'd11:   rowVals = {8'h01, 8'h01, 8'h01};
      4'd12:   rowVals = {8'h20, 8'h24, 8'h22};
      default: rowVals = '0;
    endcase
  end

  always_comb begin
    keyByte = '0;
    valByte = '0;
    if (selDac) begin
      if (int'(pairIdx) < DAC_PAIRS) begin
        keyByte = FIRST_DAC + idxByte;
        case (pairIdx[1:0])
          2'd0:    valByte = 8'hFF;
          2'd2:    valByte = 8'h70;
          default: valByte = 8'h00;
        endcase
      end
    end else if (int'(pairIdx) < TIMING_PAIRS) begin
      keyByte = (int'(pairIdx) == TIMING_PAIRS - 1) ? CTRL_OFFSET : FIRST_TIMING + idxByte;
      case (mode)
        MODE_66: valByte = rowVals[3*BYTE_W-1:2*BYTE_W];
        MODE_76: valByte = rowVals[2*BYTE_W-1:BYTE_W];
        default: valByte = rowVals[BYTE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import initSeqPkg::*;
#(
  parameter logic [7:0] DAC_IDX_PORT  = 8'h08,
  parameter logic [7:0] DAC_CTRL_PORT = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmdT            cmd,
  input  logic [BYTE_W-1:0] statusByte,
  input  logic              lowResStrap,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              pairEnd,
  output logic              unsupported
);
  modeT modeQ, modeNext;
  logic [IDX_W-1:0] pairIdx;
  logic [BYTE_W-1:0] keyByte, valByte;
  logic [2:0] resCode;

  assign resCode = statusByte[6:4];
  assign unsupported = !lowResStrap && (statusByte[3:0] != ID_COLOUR);

  always_comb begin
    if (lowResStrap) modeNext = MODE_LOW;
    else if (resCode == RES_FAST_A || resCode == RES_FAST_B) modeNext = MODE_76;
    else modeNext = MODE_66;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_66;
      pairIdx <= '0;
    end else begin
      if (cmd.loadMode) modeQ <= modeNext;
      if (cmd.clrIdx) pairIdx <= '0;
      else if (cmd.stepIdx) pairIdx <= pairIdx + 1'b1;
    end
  end

  seqRom uRom (
    .mode(modeQ),
    .selDac(cmd.selDac),
    .pairIdx(pairIdx),
    .keyByte(keyByte),
    .valByte(valByte)
  );

  assign pairEnd = (keyByte == '0);

  always_comb begin
    case (cmd.busSel)
      BUS_DAC_IDX:  begin wrAddr = DAC_IDX_PORT;  wrData = keyByte; end
      BUS_DAC_CTRL: begin wrAddr = DAC_CTRL_PORT; wrData = valByte; end
      default:      begin wrAddr = keyByte;       wrData = valByte; end
    endcase
  end

  // R6
  timing_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.strobe && cmd.busSel == BUS_TIMING) |-> (wrAddr[7:4] == 4'h1));

  // R6
  ctrl_video_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.strobe && cmd.busSel == BUS_TIMING && wrAddr == 8'h10) |-> !wrData[6]);
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import initSeqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   pairEnd,
  input  logic   unsupported,
  output seqCmdT cmd,
  output logic   done,
  output logic   error
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_TIMING, ST_DAC_IDX, ST_DAC_CTRL, ST_DONE, ST_FAIL
  } stateT;

  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    cmd = '{loadMode: 1'b0, clrIdx: 1'b0, stepIdx: 1'b0, selDac: 1'b0,
            busSel: BUS_TIMING, strobe: 1'b0};
    case (state)
      ST_IDLE: if (start) begin
        if (unsupported) stateNext = ST_FAIL;
        else begin
          cmd.loadMode = 1'b1;
          cmd.clrIdx = 1'b1;
          stateNext = ST_TIMING;
        end
      end
      ST_TIMING: begin
        if (pairEnd) begin
          cmd.clrIdx = 1'b1;
          stateNext = ST_DAC_IDX;
        end else begin
          cmd.strobe = 1'b1;
          cmd.stepIdx = 1'b1;
        end
      end
      ST_DAC_IDX: begin
        cmd.selDac = 1'b1;
        if (pairEnd) stateNext = ST_DONE;
        else begin
          cmd.strobe = 1'b1;
          cmd.busSel = BUS_DAC_IDX;
          stateNext = ST_DAC_CTRL;
        end
      end
      ST_DAC_CTRL: begin
        cmd.selDac = 1'b1;
        cmd.strobe = 1'b1;
        cmd.busSel = BUS_DAC_CTRL;
        cmd.stepIdx = 1'b1;
        stateNext = ST_DAC_IDX;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign done = (state == ST_DONE);
  assign error = (state == ST_FAIL);

  // R9
  run_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_IDLE));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R5
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |=> error);
endmodule

// File: rtl/dispInitSeq.sv
module dispInitSeq
  import initSeqPkg::*;
#(
  parameter logic [7:0] DAC_IDX_PORT  = 8'h08,
  parameter logic [7:0] DAC_CTRL_PORT = 8'h0A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] statusByte,
  input  logic       lowResStrap,
  output logic [7:0] wrAddr,
  output logic [7:0] wrData,
  output logic       wrStrobe,
  output logic       done,
  output logic       error
);
  seqCmdT cmd;
  logic pairEnd, unsupported;

  seqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .pairEnd(pairEnd),
    .unsupported(unsupported), .cmd(cmd), .done(done), .error(error)
  );

  seqDatapath #(.DAC_IDX_PORT(DAC_IDX_PORT), .DAC_CTRL_PORT(DAC_CTRL_PORT)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .statusByte(statusByte),
    .lowResStrap(lowResStrap), .wrAddr(wrAddr), .wrData(wrData),
    .pairEnd(pairEnd), .unsupported(unsupported)
  );

  assign wrStrobe = cmd.strobe;

  // R5
  error_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !wrStrobe);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrStrobe);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R7
  dac_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrAddr == DAC_CTRL_PORT) |->
      ($past(wrStrobe) && $past(wrAddr) == DAC_IDX_PORT));
endmodule

// File: tb/sim_dispInitSeq.sv
`timescale 1ns/1ps
module sim_dispInitSeq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] statusByte = 8'h00;
  logic lowResStrap = 1'b0;
  logic [7:0] wrAddr, wrData;
  logic wrStrobe, done, error;

  int checks = 0;
  int errors = 0;
  logic [15:0] cap [0:63];
  int nCap;
  int doneRises;

  always #4 clk = ~clk;

  dispInitSeq u0 (
    .clk(clk), .rstN(rstN), .start(start), .statusByte(statusByte),
    .lowResStrap(lowResStrap), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrobe(wrStrobe), .done(done), .error(error)
  );

  localparam logic [7:0] T66 [0:12] = '{8'hBB, 8'h2B, 8'h04, 8'h14, 8'hAE, 8'h03, 8'hA8,
                                       8'h24, 8'h01, 8'h05, 8'hFF, 8'h01, 8'h20};
  localparam logic [7:0] T76 [0:12] = '{8'hB7, 8'h27, 8'h03, 8'h0F, 8'hAE, 8'h03, 8'hAE,
                                       8'h2A, 8'h01, 8'h09, 8'hFF, 8'h01, 8'h24};
  localparam logic [7:0] TLO [0:12] = '{8'h70, 8'h20, 8'h08, 8'h10, 8'h06, 8'h02, 8'h31,
                                       8'h51, 8'h06, 8'h0C, 8'hFF, 8'h01, 8'h22};
  localparam logic [7:0] DACV [0:3] = '{8'hFF, 8'h00, 8'h70, 8'h00};

  // {status, strap, expected: 0=66Hz 1=76Hz 2=640x480 3=error}
  localparam logic [10:0] VECS [0:9] = '{
    {8'h41, 1'b0, 2'd1}, {8'h61, 1'b0, 2'd1}, {8'h01, 1'b0, 2'd0},
    {8'hD1, 1'b0, 2'd0}, {8'hC1, 1'b0, 2'd1}, {8'h02, 1'b1, 2'd2},
    {8'h02, 1'b0, 2'd3}, {8'h03, 1'b0, 2'd3}, {8'h00, 1'b0, 2'd3},
    {8'h41, 1'b1, 2'd2}
  };

  function automatic logic [15:0] expWrite(int m, int k);
    logic [7:0] v;
    int p;
    if (k < 13) begin
      case (m)
        0: v = T66[k];
        1: v = T76[k];
        default: v = TLO[k];
      endcase
      return {(k == 12) ? 8'h10 : 8'h14 + 8'(k), v};
    end
    p = (k - 13) / 2;
    if (((k - 13) % 2) == 0) return {8'h08, 8'h04 + 8'(p)};
    return {8'h0A, DACV[p]};
  endfunction

  function automatic string reqOf(int m);
    case (m)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!wrStrobe && !done && !error, "R1", "flags after reset",
          {wrStrobe, done, error}, 0);
  endtask

  task automatic runCase(input logic [7:0] st, input logic strap, input bit hold);
    logic prevDone;
    statusByte = st;
    lowResStrap = strap;
    start = 1'b1;
    nCap = 0;
    doneRises = 0;
    prevDone = done;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      if (wrStrobe) begin
        if (nCap < 64) cap[nCap] = {wrAddr, wrData};
        nCap++;
        if (done) check(1'b0, "R8", "write while done", 1, 0);
      end
      if (done && !prevDone) doneRises++;
      prevDone = done;
    end
    start = 1'b0;
  endtask

  task automatic verifyStream(input int m);
    string req;
    req = reqOf(m);
    if (m == 3) begin
      check(nCap == 0, "R5", "write count", nCap, 0);
      check(error && !done, "R5", "error/done", {error, done}, 2);
      return;
    end
    check(nCap == 21, req, "write count", nCap, 21);
    for (int k = 0; k < 21 && k < nCap; k++)
      check(cap[k] == expWrite(m, k), (k < 13) ? req : "R7", $sformatf("write %0d", k),
            cap[k], expWrite(m, k));
    check(cap[12][15:8] == 8'h10 && !cap[12][6], "R6", "control write last, video off",
          cap[12], expWrite(m, 12));
    check(done && !error, "R8", "done/error", {done, error}, 2);
    check(doneRises == 1, "R8", "done rises", doneRises, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int v = 0; v < 10; v++) begin
      doReset();
      runCase(VECS[v][10:3], VECS[v][2], 1'b0);
      verifyStream(int'(VECS[v][1:0]));
    end

    // R1: idle without start stays quiet
    doReset();
    nCap = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (wrStrobe || done || error) nCap++;
    end
    check(nCap == 0, "R1", "activity without start", nCap, 0);

    // R9: second start after a complete run gives nothing
    runCase(8'h01, 1'b0, 1'b0);
    verifyStream(0);
    runCase(8'h41, 1'b0, 1'b0);
    check(nCap == 0, "R9", "writes on second start", nCap, 0);
    check(done, "R9", "done held", done, 1);

    // R9: start held high across the run leaves the stream unchanged
    doReset();
    runCase(8'h61, 1'b0, 1'b1);
    verifyStream(1);

    // R5 and R9: restart after error still writes nothing
    doReset();
    runCase(8'h03, 1'b0, 1'b0);
    verifyStream(3);
    runCase(8'h01, 1'b0, 1'b0);
    check(nCap == 0 && error, "R9", "restart after error", nCap, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule